// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block consumes a stream of 32-bit command words and turns the commands into register writes on a simple valid/ready write bus. A controller first loads a small base table, where each entry maps a 24-bit region key to a region address. It then starts a stream by pulsing `go` with the stream length in words, and presents the words one at a time on a valid/ready input.

The supported commands are a contiguous-range write, a list of offset/value pairs, a lookup-table data-port write in three forms, and a base-select command. The base-select command picks the active region, and every write address is formed relative to that region. The header of each command is checked against the words left in the stream before any of its payload is taken. An unknown opcode, a missing base, a zero count or a payload that runs past the stream length stops the block with a sticky error. A stream that ends cleanly raises `done` once the last write has left the block.

Top module: `cmdx_exec`

## Requirements
- R1: After reset, `done`, `err`, `busy`, `wr_valid` and `in_ready` are all low.
- R2: A `go` pulse with `go_len` = 0 raises `done` without taking any input word.
- R3: Opcode 3 (in bits [31:24] of the first word) is a range write. Word 0 bits [15:0] give a count N, and word 1 bits [23:0] give an offset. The next N words are written, in order, to base + offset + 4*i.
- R4: Opcode 4 is a pairs write. Word 0 bits [15:0] give a count N, and N pairs follow, each an offset word and then a value word. Each value is written to base + offset.
- R5: Opcode 8 takes a 24-bit key from bits [23:0] and looks it up among the written table entries. If several entries match, the lowest index wins, and that entry's address becomes the base for later writes. If no entry matches, `err` is raised.
- R6: Opcode 1 is a three-word table command. Word 0 bits [15:0] hold L = payload bytes - 1, word 1 is ignored, and word 2 bits [23:0] hold a port address P. (L+1)/4 payload words are written to base + P + 8. When that count is 0, only the header is consumed.
- R7: Opcode 10 has the same layout as R6, but writes each payload word to base + P + 12.
- R8: Opcode 11 has the same layout as R6 and runs (L+1)/8 iterations. Each iteration writes its first word to base + P + 12 and then its second word to base + P + 8.
- R9: A command with opcode 1, 10 or 11 that arrives before any successful base selection since reset raises `err`.
- R10: Any opcode other than 1, 3, 4, 8, 10 or 11 raises `err`. Once `err` is set, it holds until reset, `in_ready` stays low, and `go` has no effect.
- R11: A range or pairs command with a count of 0 raises `err` and issues no write.
- R12: A command whose header plus payload needs more words than remain in the stream raises `err` when its first word is taken, and issues none of its writes.
- R13: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged. At most one write is issued per cycle.
- R14: `done` rises only after the last stream word has been taken and the last write has been accepted. It stays high until the next `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start a stream (accepted when idle or done) |
| go_len | input | LEN_W | Stream length in words |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Command word taken when both are high |
| in_word | input | 32 | Command word |
| tbl_we | input | 1 | Write a base table entry |
| tbl_idx | input | $clog2(N_BASE) | Table entry index |
| tbl_key | input | 24 | Region key for the entry |
| tbl_addr | input | ADDR_W | Region address for the entry |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | ADDR_W | Register write byte address |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Stream in progress or write pending |
| done | output | 1 | Stream finished cleanly |
| err | output | 1 | Sticky fault flag |

## Verification
The bench builds the block with LEN_W = 12, ADDR_W = 32 and N_BASE = 4. The 12-bit stream length lets a table command with a length field of 0xFFFF request far more payload than any stream can hold. This exercises the overrun comparison at widths where the payload count is wider than the remaining-word count. Four entries are enough to hold a duplicate key, which shows lowest-index priority, next to a distinct region used across two back-to-back streams. The write-ready line is driven in a random stall pattern, so that the range, pairs and table writes all pass through a full write stage.

// File: rtl/cmdx_pkg.sv
package cmdx_pkg;

  localparam int KEY_W = 24;

  localparam logic [7:0] OP_LUT   = 8'd1;
  localparam logic [7:0] OP_RANGE = 8'd3;
  localparam logic [7:0] OP_PAIRS = 8'd4;
  localparam logic [7:0] OP_BASE  = 8'd8;
  localparam logic [7:0] OP_LUT32 = 8'd10;
  localparam logic [7:0] OP_LUT64 = 8'd11;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR0, S_HDR1, S_HDR2, S_RANGE,
    S_PADDR, S_PVAL, S_LUT, S_DONE, S_FAULT
  } seq_state_e;

  // Header size in words; zero marks an opcode the block does not execute.
  function automatic logic [1:0] hdr_words(input logic [7:0] op);
    case (op)
      OP_LUT, OP_LUT32, OP_LUT64: hdr_words = 2'd3;
      OP_RANGE:                   hdr_words = 2'd2;
      OP_PAIRS, OP_BASE:          hdr_words = 2'd1;
      default:                    hdr_words = 2'd0;
    endcase
  endfunction

  function automatic logic is_lut(input logic [7:0] op);
    is_lut = (op == OP_LUT) || (op == OP_LUT32) || (op == OP_LUT64);
  endfunction

endpackage

// File: rtl/cmdx_base_tbl.sv
module cmdx_base_tbl #(
  parameter int N_BASE = 4,
  parameter int ADDR_W = 32,
  parameter int KEY_W  = 24,
  localparam int IDX_W = (N_BASE > 1) ? $clog2(N_BASE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [IDX_W-1:0]  prog_idx,
  input  logic [KEY_W-1:0]  prog_key,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [KEY_W-1:0]  look_key,
  output logic              look_hit,
  output logic [ADDR_W-1:0] look_addr
);

  logic [N_BASE-1:0] ent_vld;
  logic [N_BASE-1:0] ent_match;
  logic [KEY_W-1:0]  ent_key  [N_BASE];
  logic [ADDR_W-1:0] ent_addr [N_BASE];

  for (genvar g = 0; g < N_BASE; g++) begin : g_ent
    logic sel;
    assign sel = prog_we && (prog_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld[g] <= 1'b0;
      end else if (sel) begin
        ent_vld[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        ent_key[g]  <= prog_key;
        ent_addr[g] <= prog_addr;
      end
    end

    assign ent_match[g] = ent_vld[g] && (ent_key[g] == look_key);
  end

  // Scan from the top so the lowest matching index is the one kept.
  always_comb begin
    look_hit  = |ent_match;
    look_addr = '0;
    for (int i = N_BASE - 1; i >= 0; i--) begin
      if (ent_match[i]) look_addr = ent_addr[i];
    end
  end

endmodule

// File: rtl/cmdx_wr_stage.sv
module cmdx_wr_stage #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_data,
  output logic              slot_free,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data
);

  logic              v_q, v_d;
  logic [ADDR_W-1:0] a_q;
  logic [31:0]       d_q;
  logic              load;

  assign slot_free = !v_q || wr_ready;
  assign load      = req_valid && slot_free;

  always_comb begin
    v_d = v_q;
    if (load)          v_d = 1'b1;
    else if (wr_ready) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      a_q <= req_addr;
      d_q <= req_data;
    end
  end

  assign wr_valid = v_q;
  assign wr_addr  = a_q;
  assign wr_data  = d_q;

endmodule

// File: rtl/cmdx_seq.sv
module cmdx_seq
  import cmdx_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [LEN_W-1:0]  go_len,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  output logic              in_ready,
  output logic [KEY_W-1:0]  look_key,
  input  logic              look_hit,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_data,
  input  logic              slot_free,
  input  logic              drained,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int CNT_W  = 17;
  localparam int NEED_W = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 2;
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_HI = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_LO = ADDR_W'(12);

  seq_state_e        state_q, state_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        op_q, op_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              hi_q, hi_d;
  logic              bok_q, bok_d;
  logic [ADDR_W-1:0] base_q, base_d;

  logic              take;
  logic [7:0]        op_w;
  logic [15:0]       f16;
  logic [16:0]       bytes_w;
  logic [CNT_W-1:0]  payload;
  logic [NEED_W-1:0] need;
  logic              hdr_fault;
  logic [LEN_W-1:0]  rem_dec;
  logic              last_word;
  logic [ADDR_W-1:0] off24;
  seq_state_e        after_cmd;

  assign op_w      = in_word[31:24];
  assign f16       = in_word[15:0];
  assign bytes_w   = {1'b0, f16} + 17'd1;
  assign look_key  = in_word[KEY_W-1:0];
  assign off24     = ADDR_W'(in_word[KEY_W-1:0]);
  assign rem_dec   = rem_q - LEN_W'(1);
  assign last_word = (rem_dec == '0);
  assign after_cmd = last_word ? S_DONE : S_HDR0;
  assign take      = in_valid && in_ready;

  // Payload words declared by a first word
  always_comb begin
    case (op_w)
      OP_RANGE:        payload = {1'b0, f16};
      OP_PAIRS:        payload = {f16, 1'b0};
      OP_LUT, OP_LUT32: payload = {2'b00, bytes_w[16:2]};
      OP_LUT64:        payload = {2'b00, bytes_w[16:3], 1'b0};
      default:         payload = '0;
    endcase
  end

  assign need = NEED_W'(hdr_words(op_w)) + NEED_W'(payload);

  always_comb begin
    hdr_fault = 1'b0;
    if (hdr_words(op_w) == 2'd0)                                hdr_fault = 1'b1;
    if (need > NEED_W'(rem_q))                                  hdr_fault = 1'b1;
    if (((op_w == OP_RANGE) || (op_w == OP_PAIRS)) && (f16 == '0)) hdr_fault = 1'b1;
    if (is_lut(op_w) && !bok_q)                                 hdr_fault = 1'b1;
    if ((op_w == OP_BASE) && !look_hit)                         hdr_fault = 1'b1;
  end

  always_comb begin
    case (state_q)
      S_HDR0, S_HDR1, S_HDR2, S_PADDR: in_ready = 1'b1;
      S_RANGE, S_PVAL, S_LUT:          in_ready = slot_free;
      default:                         in_ready = 1'b0;
    endcase
  end

  // Next-state process
  always_comb begin
    state_d   = state_q;
    rem_d     = rem_q;
    cnt_d     = cnt_q;
    op_d      = op_q;
    ptr_d     = ptr_q;
    hi_d      = hi_q;
    bok_d     = bok_q;
    base_d    = base_q;
    req_valid = 1'b0;
    req_addr  = ptr_q;
    req_data  = in_word;

    if (take) rem_d = rem_dec;

    case (state_q)
      S_IDLE, S_DONE: begin
        if (go) begin
          rem_d   = go_len;
          state_d = (go_len == '0) ? S_DONE : S_HDR0;
        end
      end
      S_HDR0: begin
        if (take) begin
          if (hdr_fault) begin
            state_d = S_FAULT;
          end else begin
            op_d  = op_w;
            cnt_d = payload;
            case (op_w)
              OP_BASE: begin
                base_d  = look_addr;
                bok_d   = 1'b1;
                state_d = after_cmd;
              end
              OP_PAIRS: begin
                cnt_d   = {1'b0, f16};
                state_d = S_PADDR;
              end
              default: state_d = S_HDR1;
            endcase
          end
        end
      end
      S_HDR1: begin
        if (take) begin
          if (op_q == OP_RANGE) begin
            ptr_d   = base_q + off24;
            state_d = S_RANGE;
          end else begin
            state_d = S_HDR2;
          end
        end
      end
      S_HDR2: begin
        if (take) begin
          ptr_d   = base_q + off24;
          hi_d    = 1'b0;
          state_d = (cnt_q == '0) ? after_cmd : S_LUT;
        end
      end
      S_RANGE: begin
        if (take) begin
          req_valid = 1'b1;
          ptr_d     = ptr_q + STEP;
          cnt_d     = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) state_d = after_cmd;
        end
      end
      S_PADDR: begin
        if (take) begin
          ptr_d   = base_q + ADDR_W'(in_word);
          state_d = S_PVAL;
        end
      end
      S_PVAL: begin
        if (take) begin
          req_valid = 1'b1;
          cnt_d     = cnt_q - CNT_W'(1);
          state_d   = (cnt_q == CNT_W'(1)) ? after_cmd : S_PADDR;
        end
      end
      S_LUT: begin
        if (op_q == OP_LUT)        req_addr = ptr_q + OFS_HI;
        else if (op_q == OP_LUT32) req_addr = ptr_q + OFS_LO;
        else                       req_addr = ptr_q + (hi_q ? OFS_HI : OFS_LO);
        if (take) begin
          req_valid = 1'b1;
          hi_d      = !hi_q;
          cnt_d     = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) state_d = after_cmd;
        end
      end
      default: state_d = S_FAULT;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rem_q   <= '0;
      cnt_q   <= '0;
      op_q    <= '0;
      ptr_q   <= '0;
      hi_q    <= 1'b0;
      bok_q   <= 1'b0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      ptr_q   <= ptr_d;
      hi_q    <= hi_d;
      bok_q   <= bok_d;
      base_q  <= base_d;
    end
  end

  assign err  = (state_q == S_FAULT);
  assign done = (state_q == S_DONE) && drained;
  assign busy = !drained ||
                !((state_q == S_IDLE) || (state_q == S_DONE) || (state_q == S_FAULT));

endmodule

// File: rtl/cmdx_exec.sv
module cmdx_exec
  import cmdx_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32,
  parameter int N_BASE = 4,
  localparam int IDX_W = (N_BASE > 1) ? $clog2(N_BASE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [LEN_W-1:0]  go_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_word,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [KEY_W-1:0]  tbl_key,
  input  logic [ADDR_W-1:0] tbl_addr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              busy,
  output logic              done,
  output logic              err
);

  logic [KEY_W-1:0]  look_key;
  logic              look_hit;
  logic [ADDR_W-1:0] look_addr;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_data;
  logic              slot_free;

  cmdx_base_tbl #(.N_BASE(N_BASE), .ADDR_W(ADDR_W), .KEY_W(KEY_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_we   (tbl_we),
    .prog_idx  (tbl_idx),
    .prog_key  (tbl_key),
    .prog_addr (tbl_addr),
    .look_key  (look_key),
    .look_hit  (look_hit),
    .look_addr (look_addr)
  );

  cmdx_seq #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_len    (go_len),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .in_ready  (in_ready),
    .look_key  (look_key),
    .look_hit  (look_hit),
    .look_addr (look_addr),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .slot_free (slot_free),
    .drained   (!wr_valid),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  cmdx_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .slot_free (slot_free),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

endmodule

// File: rtl/cmdx_exec_chk.sv
module cmdx_exec_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              busy,
  input logic              done,
  input logic              err
);

  // R13: a stalled write holds its payload
  p_stall_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R10: the fault flag is sticky
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R10: no words are taken while faulted
  p_err_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready);

  // R14: completion only with the write stage empty and no fault
  p_done_drained_r14: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!wr_valid && !err && !busy));

  // R13: a pending write keeps the block busy
  p_pending_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);

endmodule

bind cmdx_exec cmdx_exec_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .busy     (busy),
  .done     (done),
  .err      (err)
);

// File: tb/tb_cmdx_exec.sv
module tb_cmdx_exec;

  localparam int LEN_W  = 12;
  localparam int ADDR_W = 32;
  localparam int N_BASE = 4;

  logic              clk;
  logic              rst_n;
  logic              go;
  logic [LEN_W-1:0]  go_len;
  logic              in_valid;
  logic              in_ready;
  logic [31:0]       in_word;
  logic              tbl_we;
  logic [1:0]        tbl_idx;
  logic [23:0]       tbl_key;
  logic [ADDR_W-1:0] tbl_addr;
  logic              wr_valid;
  logic              wr_ready;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic              busy;
  logic              done;
  logic              err;

  cmdx_exec #(.LEN_W(LEN_W), .ADDR_W(ADDR_W), .N_BASE(N_BASE)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [31:0] stream[$];
  int          tests = 0;
  int          fails = 0;
  bit          stall_mode = 1'b0;
  bit          finished = 1'b0;
  logic [31:0] cur_base;
  logic [31:0] dseed = 32'hA500_0000;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // Write-ready driver
  initial begin
    wr_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      wr_ready = stall_mode ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // Monitor: pop and compare every accepted write; watch stalls (R13)
  logic        prev_stall = 1'b0;
  logic [31:0] prev_a, prev_d;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          chk(wr_valid && (wr_addr == prev_a) && (wr_data == prev_d), "R13",
              "stalled write changed", wr_addr, prev_a);
        end
        prev_stall = wr_valid && !wr_ready;
        prev_a     = wr_addr;
        prev_d     = wr_data;
        if (wr_valid && wr_ready) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R12", "unexpected write addr", wr_addr, 32'h0);
          end else begin
            exp_t e;
            e = expq.pop_front();
            chk(wr_addr == e.a, e.tag, "write addr", wr_addr, e.a);
            chk(wr_data == e.d, e.tag, "write data", wr_data, e.d);
          end
        end
      end else begin
        prev_stall = 1'b0;
      end
    end
  end

  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    expq.push_back(e);
  endtask

  function automatic logic [31:0] next_data();
    dseed = dseed + 32'h0001_0011;
    return dseed;
  endfunction

  // Stream builders
  task automatic add_base(input logic [23:0] key, input logic [31:0] region);
    stream.push_back({8'd8, key});
    cur_base = region;
  endtask

  task automatic add_range(input logic [23:0] off, input int n);
    stream.push_back({8'd3, 8'd0, 16'(n)});
    stream.push_back({8'd0, off});
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = next_data();
      stream.push_back(d);
      expect_wr(cur_base + {8'd0, off} + 32'(4 * i), d, "R3");
    end
  endtask

  task automatic add_pairs(input int n, input string tag);
    stream.push_back({8'd4, 8'd0, 16'(n)});
    for (int i = 0; i < n; i++) begin
      logic [31:0] off, d;
      off = 32'h0000_0100 + 32'(i * 36);
      d   = next_data();
      stream.push_back(off);
      stream.push_back(d);
      expect_wr(cur_base + off, d, tag);
    end
  endtask

  task automatic add_lut(input logic [7:0] op, input logic [23:0] port, input int len);
    int n;
    stream.push_back({op, 8'd0, 16'(len)});
    stream.push_back(32'hDEAD_0000);
    stream.push_back({8'h5A, port});
    if (op == 8'd11) begin
      n = (len + 1) / 8;
      for (int i = 0; i < n; i++) begin
        logic [31:0] lo, hi;
        lo = next_data();
        hi = next_data();
        stream.push_back(lo);
        stream.push_back(hi);
        expect_wr(cur_base + {8'd0, port} + 32'd12, lo, "R8");
        expect_wr(cur_base + {8'd0, port} + 32'd8, hi, "R8");
      end
    end else begin
      n = (len + 1) / 4;
      for (int i = 0; i < n; i++) begin
        logic [31:0] d;
        d = next_data();
        stream.push_back(d);
        expect_wr(cur_base + {8'd0, port} + ((op == 8'd1) ? 32'd8 : 32'd12), d,
                  (op == 8'd1) ? "R6" : "R7");
      end
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    go       = 1'b0;
    go_len   = '0;
    in_valid = 1'b0;
    in_word  = '0;
    tbl_we   = 1'b0;
    tbl_idx  = '0;
    tbl_key  = '0;
    tbl_addr = '0;
    expq.delete();
    stream.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic prog(input logic [1:0] idx, input logic [23:0] key, input logic [31:0] a);
    @(posedge clk);
    #1;
    tbl_we = 1'b1; tbl_idx = idx; tbl_key = key; tbl_addr = a;
    @(posedge clk);
    #1;
    tbl_we = 1'b0;
  endtask

  task automatic prog_all();
    prog(2'd0, 24'h000100, 32'h4000_0000);
    prog(2'd1, 24'h000200, 32'h5000_0000);
    prog(2'd2, 24'h000200, 32'h6000_0000);
    prog(2'd3, 24'h000300, 32'h7000_1000);
  endtask

  task automatic start(input int len);
    @(posedge clk);
    #1;
    go = 1'b1; go_len = LEN_W'(len);
    @(posedge clk);
    #1;
    go = 1'b0;
  endtask

  task automatic send(input logic [31:0] w, output bit ok);
    int wait_n;
    in_valid = 1'b1;
    in_word  = w;
    wait_n   = 0;
    ok       = 1'b0;
    while (!ok && wait_n < 60) begin
      @(negedge clk);
      if (in_ready) ok = 1'b1;
      wait_n++;
    end
    if (ok) begin
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic run_stream();
    bit ok;
    start(stream.size());
    for (int i = 0; i < stream.size(); i++) begin
      send(stream[i], ok);
      if (!ok) break;
    end
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, tag, "done not raised", 32'(done), 32'd1);
    chk(expq.size() == 0, tag, "writes missing", 32'(expq.size()), 32'd0);
    chk(wr_valid == 1'b0, tag, "write pending at done", 32'(wr_valid), 32'd0);
  endtask

  task automatic expect_fault(input string tag);
    repeat (20) @(negedge clk);
    chk(err == 1'b1, tag, "err", 32'(err), 32'd1);
    chk(in_ready == 1'b0, tag, "in_ready after fault", 32'(in_ready), 32'd0);
    chk(done == 1'b0, tag, "done after fault", 32'(done), 32'd0);
    chk(expq.size() == 0, tag, "writes before fault missing", 32'(expq.size()), 32'd0);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk(!done && !err && !busy && !wr_valid && !in_ready, "R1", "reset outputs",
        {27'd0, done, err, busy, wr_valid, in_ready}, 32'd0);

    prog_all();

    // R2: empty stream
    start(0);
    @(negedge clk);
    chk(done == 1'b1, "R2", "done on empty stream", 32'(done), 32'd1);
    chk(in_ready == 1'b0, "R2", "in_ready on empty stream", 32'(in_ready), 32'd0);

    // Mixed stream with write stalls: R3 R4 R5 R6 R7 R8 R13 R14
    stall_mode = 1'b1;
    stream.delete();
    add_base(24'h000100, 32'h4000_0000);
    add_range(24'h000010, 3);
    add_pairs(2, "R4");
    add_lut(8'd1, 24'h000080, 7);
    add_lut(8'd1, 24'h000090, 2);      // R6: zero payload words
    add_lut(8'd10, 24'h0000A0, 3);
    add_lut(8'd11, 24'h0000B0, 15);
    add_base(24'h000200, 32'h5000_0000); // R5: index 1 wins over index 2
    add_pairs(1, "R5");
    add_range(24'h000000, 1);
    run_stream();
    wait_done("R14");
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R14", "done held", 32'(done), 32'd1);

    // Second stream from done, no stalls
    stall_mode = 1'b0;
    stream.delete();
    add_base(24'h000300, 32'h7000_1000);
    add_lut(8'd11, 24'h000040, 7);
    add_range(24'h000200, 4);
    run_stream();
    wait_done("R8");

    // R9: table command before any base
    do_reset(); prog_all();
    stream.push_back({8'd1, 8'd0, 16'd7});
    stream.push_back(32'h0); stream.push_back(32'h0);
    stream.push_back(32'h1); stream.push_back(32'h2);
    run_stream();
    expect_fault("R9");

    // R10: unknown opcode, then go ignored
    do_reset(); prog_all();
    stream.push_back({8'd7, 24'h0});
    stream.push_back(32'h0); stream.push_back(32'h0);
    run_stream();
    expect_fault("R10");
    start(4);
    @(negedge clk);
    chk(err && !in_ready && !busy, "R10", "go while faulted",
        {29'd0, err, in_ready, busy}, 32'd4);

    // R11: zero count
    do_reset(); prog_all();
    add_base(24'h000100, 32'h4000_0000);
    stream.push_back({8'd3, 8'd0, 16'd0});
    stream.push_back(32'h10);
    run_stream();
    expect_fault("R11");

    // R12: payload overrun after a good command
    do_reset(); prog_all();
    add_base(24'h000100, 32'h4000_0000);
    add_range(24'h000020, 2);
    stream.push_back({8'd4, 8'd0, 16'd3});
    stream.push_back(32'h4); stream.push_back(32'h5);
    run_stream();
    expect_fault("R12");

    // R12: huge table length field
    do_reset(); prog_all();
    add_base(24'h000100, 32'h4000_0000);
    stream.push_back({8'd10, 8'd0, 16'hFFFF});
    stream.push_back(32'h0); stream.push_back(32'h0); stream.push_back(32'h1);
    run_stream();
    expect_fault("R12");

    // R12: header itself past the end
    do_reset(); prog_all();
    add_base(24'h000100, 32'h4000_0000);
    stream.push_back({8'd1, 8'd0, 16'd3});
    run_stream();
    expect_fault("R12");

    // R5: base key with no entry
    do_reset(); prog_all();
    stream.push_back({8'd8, 24'h000999});
    stream.push_back({8'd4, 8'd0, 16'd1});
    stream.push_back(32'h0); stream.push_back(32'h1);
    run_stream();
    expect_fault("R5");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule